// File: doc/BRIEF.md
# Cache Line Writeback and Writeclean Handler

This block sits inside a write-back cache controller and absorbs incoming full-line writeback and writeclean requests. Each request carries a line address, a secure attribute, a write-through flag, the whole line of data and two delay figures. The block looks the line up in its tag array. It then decides whether to allocate, update, or leave the line alone. It reports whether the request finished at this level, or places it in a one-entry forward register for the level below.

A write-through request never allocates on a miss and never marks a line dirty. It always continues downstream, even when it has just refreshed a resident copy. A plain request that misses takes the way named by a victim-select input. When that input reports no replaceable way, a miss counter is bumped and the request goes downstream. If the victim was a dirty line, its address is announced on a one-cycle eviction pulse.

A second command port builds a writeclean from a resident dirty line. The outgoing writeclean always declares that sharers exist, since the local copy is kept. It copies the optional destination flags, and any destination sets its write-through flag. The local copy becomes clean.

Top module: `wb_clean_handler`

## Requirements
- R1: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low while `wc_go` is high, and while the forward register holds an entry that `fwd_ready` does not take in that cycle.
- R2: A request that hits with `req_wt` low replaces the line data and marks the line dirty. It reports `res_local`=1, `res_hit`=1 and loads nothing into the forward register.
- R3: A request that hits with `req_wt` high replaces the line data and leaves the dirty bit unchanged. It reports `res_local`=0 and is forwarded with its address, secure bit, write-through flag and data unchanged.
- R4: A request that misses with `req_wt` high allocates nothing, leaves the miss counter unchanged and is forwarded.
- R5: A request that misses with `req_wt` low while `vic_ok` is high fills way `vic_way` of the indexed set. The line becomes valid and dirty, takes `req_secure` as its secure bit, and the request reports `res_local`=1.
- R6: When that fill replaces a valid dirty line, `wb_valid` pulses for one cycle together with the result. `wb_addr` carries the replaced line's address with the offset bits zero.
- R7: A request that misses with `req_wt` low while `vic_ok` is low adds one to `miss_cnt` and is forwarded.
- R8: `res_valid` is high for exactly the cycle after a request is taken. When the line was written, `res_delay` equals FILL_LAT + `req_hdr_dly` + `req_pay_dly`; otherwise it is 0.
- R9: A `wc_go` command (address bits [LA_W-1:IDX_W] tag, [IDX_W-1:0] set) that finds a resident dirty line pulses `wcl_valid` in the next cycle. The pulse carries the line-aligned address, data, secure bit, `wcl_shared`=1, `wcl_dest`=`wc_dest` and `wcl_wt`=1 exactly when `wc_dest` is non-zero. Bit 1 of `wc_dest` names the coherence point and bit 0 the unification point. The line becomes clean.
- R10: A `wc_go` command that finds the line absent or clean pulses `wcl_none` instead and changes nothing.
- R11: While `fwd_valid` is high and `fwd_ready` is low, the forward register holds its contents unchanged.
- R12: After reset, every line is invalid, `miss_cnt` is 0, and `res_valid`, `fwd_valid`, `wb_valid`, `wcl_valid` and `wcl_none` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | ADDR_W | Request address |
| req_secure | input | 1 | Secure attribute |
| req_wt | input | 1 | Write-through flag |
| req_data | input | LINE_W | Full line data |
| req_hdr_dly | input | DLY_W | Header delay in cycles |
| req_pay_dly | input | DLY_W | Payload delay in cycles |
| vic_way | input | WAY_W | Way offered for replacement |
| vic_ok | input | 1 | A replaceable way exists |
| res_valid | output | 1 | Result pulse |
| res_local | output | 1 | Request finished at this level |
| res_hit | output | 1 | Request hit a resident line |
| res_delay | output | RD_W | Cycles until the written line is usable |
| miss_cnt | output | CNT_W | Unplaceable-miss counter |
| wb_valid | output | 1 | Dirty victim evicted |
| wb_addr | output | ADDR_W | Evicted line address |
| fwd_valid | output | 1 | Forward entry present |
| fwd_ready | input | 1 | Level below takes the entry |
| fwd_addr | output | ADDR_W | Forwarded address |
| fwd_secure | output | 1 | Forwarded secure attribute |
| fwd_wt | output | 1 | Forwarded write-through flag |
| fwd_data | output | LINE_W | Forwarded line data |
| wc_go | input | 1 | Writeclean build command |
| wc_line | input | LA_W | Line address for the command |
| wc_dest | input | 2 | Destination flags |
| wcl_valid | output | 1 | Writeclean produced |
| wcl_none | output | 1 | No dirty line to clean |
| wcl_addr | output | ADDR_W | Writeclean address |
| wcl_data | output | LINE_W | Writeclean data |
| wcl_secure | output | 1 | Writeclean secure attribute |
| wcl_shared | output | 1 | Sharers-present marker |
| wcl_wt | output | 1 | Writeclean write-through flag |
| wcl_dest | output | 2 | Writeclean destination flags |

## Verification
A corrupted dirty bit appears at the next writeclean command to that line. The command answers with `wcl_none` instead of `wcl_valid`, or the reverse, one cycle after the command. A wrong tag, valid or secure bit shows on the next request to the line as a wrong `res_hit`, `res_local` or forward decision, or as a wrong writeclean address or secure flag. Stale line data surfaces on `wcl_data`. A lost eviction shows as a missing `wb_valid` in the result cycle. A miscount shows on `miss_cnt` in the result cycle of the miss itself.

// File: rtl/wb_clean_handler.sv
module wb_clean_handler #(
  parameter int ADDR_W     = 16,
  parameter int LINE_BYTES = 8,
  parameter int SETS       = 4,
  parameter int WAYS       = 2,
  parameter int DLY_W      = 6,
  parameter int FILL_LAT   = 3,
  parameter int CNT_W      = 16,
  localparam int LINE_W = LINE_BYTES * 8,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int IDX_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W,
  localparam int LA_W   = ADDR_W - OFF_W,
  localparam int RD_W   = DLY_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_secure,
  input  logic              req_wt,
  input  logic [LINE_W-1:0] req_data,
  input  logic [DLY_W-1:0]  req_hdr_dly,
  input  logic [DLY_W-1:0]  req_pay_dly,
  input  logic [WAY_W-1:0]  vic_way,
  input  logic              vic_ok,
  output logic              res_valid,
  output logic              res_local,
  output logic              res_hit,
  output logic [RD_W-1:0]   res_delay,
  output logic [CNT_W-1:0]  miss_cnt,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic              fwd_valid,
  input  logic              fwd_ready,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic              fwd_secure,
  output logic              fwd_wt,
  output logic [LINE_W-1:0] fwd_data,
  input  logic              wc_go,
  input  logic [LA_W-1:0]   wc_line,
  input  logic [1:0]        wc_dest,
  output logic              wcl_valid,
  output logic              wcl_none,
  output logic [ADDR_W-1:0] wcl_addr,
  output logic [LINE_W-1:0] wcl_data,
  output logic              wcl_secure,
  output logic              wcl_shared,
  output logic              wcl_wt,
  output logic [1:0]        wcl_dest
);

  localparam int ENT   = SETS * WAYS;
  localparam int ENT_W = IDX_W + WAY_W;

  logic [TAG_W-1:0]  tag_q [ENT];
  logic [LINE_W-1:0] dat_q [ENT];
  logic [ENT-1:0]    vld_q, drt_q, sec_q;

  logic [IDX_W-1:0] lk_idx;
  logic [TAG_W-1:0] lk_tag;
  logic [WAYS-1:0]  hv;
  logic [WAY_W-1:0] hit_way;
  logic [ENT_W-1:0] he, ve;
  logic hit, acc, alloc, wr_line, local_done, no_room, vic_dirty, wc_dirty;

  assign lk_idx = wc_go ? wc_line[IDX_W-1:0] : req_addr[OFF_W +: IDX_W];
  assign lk_tag = wc_go ? wc_line[LA_W-1:IDX_W] : req_addr[ADDR_W-1 -: TAG_W];

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    assign hv[g] = vld_q[{lk_idx, WAY_W'(g)}] && (tag_q[{lk_idx, WAY_W'(g)}] == lk_tag);
  end

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (hv[w]) hit_way = WAY_W'(w);
  end

  assign hit        = |hv;
  assign he         = {lk_idx, hit_way};
  assign ve         = {lk_idx, vic_way};
  assign req_ready  = (!fwd_valid || fwd_ready) && !wc_go;
  assign acc        = req_valid && req_ready;
  assign alloc      = acc && !hit && !req_wt && vic_ok;
  assign no_room    = acc && !hit && !req_wt && !vic_ok;
  assign wr_line    = acc && (hit || alloc);
  assign local_done = acc && !req_wt && (hit || vic_ok);
  assign vic_dirty  = vld_q[ve] && drt_q[ve];
  assign wc_dirty   = wc_go && hit && drt_q[he];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q     <= '0;
      drt_q     <= '0;
      sec_q     <= '0;
      res_valid <= 1'b0;
      res_local <= 1'b0;
      res_hit   <= 1'b0;
      res_delay <= '0;
      miss_cnt  <= '0;
      wb_valid  <= 1'b0;
      fwd_valid <= 1'b0;
      wcl_valid <= 1'b0;
      wcl_none  <= 1'b0;
    end else begin
      res_valid <= acc;
      res_local <= local_done;
      res_hit   <= acc && hit;
      res_delay <= wr_line ? RD_W'(FILL_LAT) + RD_W'(req_hdr_dly) + RD_W'(req_pay_dly) : '0;
      wb_valid  <= alloc && vic_dirty;
      wcl_valid <= wc_dirty;
      wcl_none  <= wc_go && !wc_dirty;
      if (no_room) miss_cnt <= miss_cnt + 1'b1;
      if (acc && !local_done) fwd_valid <= 1'b1;
      else if (fwd_ready)     fwd_valid <= 1'b0;
      if (alloc) begin
        vld_q[ve] <= 1'b1;
        drt_q[ve] <= 1'b1;
        sec_q[ve] <= req_secure;
      end else if (acc && hit && !req_wt) begin
        drt_q[he] <= 1'b1;
      end else if (wc_dirty) begin
        drt_q[he] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (alloc) tag_q[ve] <= lk_tag;
    if (wr_line) dat_q[alloc ? ve : he] <= req_data;
    if (alloc && vic_dirty) wb_addr <= {tag_q[ve], lk_idx, {OFF_W{1'b0}}};
    if (acc && !local_done) begin
      fwd_addr   <= req_addr;
      fwd_secure <= req_secure;
      fwd_wt     <= req_wt;
      fwd_data   <= req_data;
    end
    if (wc_dirty) begin
      wcl_addr   <= {lk_tag, lk_idx, {OFF_W{1'b0}}};
      wcl_data   <= dat_q[he];
      wcl_secure <= sec_q[he];
      wcl_shared <= 1'b1;
      wcl_dest   <= wc_dest;
      wcl_wt     <= |wc_dest;
    end
  end

endmodule

// File: rtl/wbch_chk.sv
module wbch_chk #(
  parameter int ADDR_W     = 16,
  parameter int LINE_BYTES = 8,
  parameter int DLY_W      = 6,
  parameter int CNT_W      = 16,
  localparam int LINE_W = LINE_BYTES * 8,
  localparam int RD_W   = DLY_W + 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              wc_go,
  input logic              res_valid,
  input logic              res_local,
  input logic              res_hit,
  input logic [RD_W-1:0]   res_delay,
  input logic [CNT_W-1:0]  miss_cnt,
  input logic              wb_valid,
  input logic              fwd_valid,
  input logic              fwd_ready,
  input logic [ADDR_W-1:0] fwd_addr,
  input logic [LINE_W-1:0] fwd_data,
  input logic              fwd_wt,
  input logic              wcl_valid,
  input logic              wcl_none,
  input logic              wcl_wt,
  input logic [1:0]        wcl_dest,
  input logic              wcl_shared
);

  assert_ready_blocked_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wc_go |-> !req_ready);

  assert_fwd_matches_local_R2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (fwd_valid == !res_local));

  assert_evict_with_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (res_valid && res_local && !res_hit));

  assert_miss_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_cnt != $past(miss_cnt)) |->
      (res_valid && !res_local && !res_hit && miss_cnt == CNT_W'($past(miss_cnt) + 1'b1)));

  assert_no_delay_unwritten_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit && !res_local) |-> (res_delay == '0));

  assert_wcl_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wcl_valid |-> (wcl_shared && (wcl_wt == (wcl_dest != 2'b00))));

  assert_wcl_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wcl_valid && wcl_none));

  assert_fwd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && !fwd_ready) |=>
      (fwd_valid && $stable(fwd_addr) && $stable(fwd_data) && $stable(fwd_wt)));

endmodule

bind wb_clean_handler wbch_chk #(
  .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .DLY_W(DLY_W), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/wb_clean_handler_test.sv
`timescale 1ns/1ps
module wb_clean_handler_test;
  localparam int FILL = 3;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_secure = 0, req_wt = 0, vic_ok = 0, fwd_ready = 1, wc_go = 0;
  logic [15:0] req_addr = 0;
  logic [63:0] req_data = 0;
  logic [5:0]  req_hdr_dly = 0, req_pay_dly = 0;
  logic [0:0]  vic_way = 0;
  logic [12:0] wc_line = 0;
  logic [1:0]  wc_dest = 0;
  logic req_ready, res_valid, res_local, res_hit, wb_valid, fwd_valid, fwd_secure, fwd_wt;
  logic wcl_valid, wcl_none, wcl_secure, wcl_shared, wcl_wt;
  logic [7:0]  res_delay;
  logic [15:0] miss_cnt, wb_addr, fwd_addr, wcl_addr;
  logic [63:0] fwd_data, wcl_data;
  logic [1:0]  wcl_dest;

  wb_clean_handler uut (.*);

  always #2.5 clk = ~clk;

  int vectors = 0, errors = 0;
  bit done = 0;
  logic        m_vld [8], m_drt [8], m_sec [8];
  logic [10:0] m_tag [8];
  logic [63:0] m_dat [8];
  logic [15:0] m_miss = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int find(input logic [15:0] a);
    for (int w = 0; w < 2; w++)
      if (m_vld[a[4:3]*2+w] && m_tag[a[4:3]*2+w] == a[15:5]) return a[4:3]*2+w;
    return -1;
  endfunction

  task automatic do_req(input logic [15:0] a, input logic s, input logic w, input logic [63:0] d,
                        input logic [5:0] h, input logic [5:0] p, input logic vw, input logic vo);
    int e, ve;
    logic hit, alloc, loc, wbx;
    logic [15:0] wba;
    logic [7:0] dly;
    e = find(a);
    hit = (e >= 0);
    ve = a[4:3]*2 + int'(vw);
    alloc = !hit && !w && vo;
    loc = !w && (hit || vo);
    wbx = alloc && m_vld[ve] && m_drt[ve];
    wba = {m_tag[ve], a[4:3], 3'b000};
    dly = (hit || alloc) ? 8'(FILL + int'(h) + int'(p)) : 8'd0;
    if (!hit && !w && !vo) m_miss++;
    if (hit) begin
      m_dat[e] = d;
      if (!w) m_drt[e] = 1;
    end else if (alloc) begin
      m_vld[ve] = 1; m_drt[ve] = 1; m_sec[ve] = s; m_tag[ve] = a[15:5]; m_dat[ve] = d;
    end
    @(negedge clk);
    req_valid = 1; req_addr = a; req_secure = s; req_wt = w; req_data = d;
    req_hdr_dly = h; req_pay_dly = p; vic_way = vw; vic_ok = vo;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    chk("R8 res_valid", res_valid, 1);
    chk("R2/R5 res_local", res_local, loc);
    chk("R2/R3 res_hit", res_hit, hit);
    chk("R8 res_delay", res_delay, dly);
    chk("R7 miss_cnt", miss_cnt, m_miss);
    chk("R6 wb_valid", wb_valid, wbx);
    if (wbx) chk("R6 wb_addr", wb_addr, wba);
    chk("R3/R4 fwd_valid", fwd_valid, !loc);
    if (!loc) chk("R3 fwd fields", {fwd_addr, fwd_secure, fwd_wt, fwd_data[45:0]},
                  {a, s, w, d[45:0]});
  endtask

  task automatic do_wc(input logic [15:0] a, input logic [1:0] dest);
    int e;
    logic dirty;
    e = find(a);
    dirty = (e >= 0) && m_drt[e];
    @(negedge clk);
    wc_go = 1; wc_line = a[15:3]; wc_dest = dest;
    #0.5;
    chk("R1 req_ready low during wc_go", req_ready, 0);
    @(negedge clk);
    wc_go = 0;
    chk("R9 wcl_valid", wcl_valid, dirty);
    chk("R10 wcl_none", wcl_none, !dirty);
    if (dirty) begin
      chk("R9 wcl_addr", wcl_addr, {a[15:3], 3'b000});
      chk("R9 wcl_data", wcl_data, m_dat[e]);
      chk("R9 wcl flags", {wcl_secure, wcl_shared, wcl_wt, wcl_dest},
          {m_sec[e], 1'b1, |dest, dest});
      m_drt[e] = 0;
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      vectors++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 8; i++) begin m_vld[i] = 0; m_drt[i] = 0; m_sec[i] = 0; m_tag[i] = 0; m_dat[i] = 0; end
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    chk("R12 res_valid", res_valid, 0);
    chk("R12 fwd_valid", fwd_valid, 0);
    chk("R12 miss_cnt", miss_cnt, 0);
    chk("R12 wb/wcl", {wb_valid, wcl_valid, wcl_none}, 0);
    chk("R1 req_ready idle", req_ready, 1);

    do_req(16'h0048, 0, 1, 64'h1111, 2, 3, 0, 1);
    do_wc(16'h0048, 0);
    do_req(16'h0090, 0, 0, 64'h2222, 1, 1, 0, 0);
    do_req(16'h0048, 1, 0, 64'h3333, 4, 5, 0, 1);
    do_wc(16'h0048, 0);
    do_wc(16'h0048, 0);
    do_req(16'h004C, 0, 1, 64'h4444, 0, 0, 1, 1);
    do_wc(16'h0048, 0);
    do_req(16'h0048, 0, 0, 64'h5555, 63, 63, 1, 0);
    do_wc(16'h0048, 2'b10);
    do_req(16'h0128, 0, 0, 64'h6666, 0, 0, 1, 1);
    do_req(16'h0248, 0, 0, 64'h7777, 0, 0, 1, 1);

    fwd_ready = 0;
    do_req(16'h0300, 1, 1, 64'hABCD, 0, 0, 0, 1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R11 fwd held", {fwd_valid, fwd_addr, fwd_data[46:0]}, {1'b1, 16'h0300, 47'hABCD});
      chk("R1 req_ready blocked", req_ready, 0);
    end
    fwd_ready = 1;
    #0.5;
    chk("R1 req_ready on drain", req_ready, 1);

    for (int n = 0; n < 400; n++) begin
      logic [15:0] a;
      a = {9'd0, 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), 3'($urandom_range(0, 7))};
      if ($urandom_range(0, 3) == 0)
        do_wc(a, 2'($urandom_range(0, 3)));
      else
        do_req(a, 1'($urandom), 1'($urandom_range(0, 2) == 0), {$urandom, $urandom},
               6'($urandom), 6'($urandom), 1'($urandom), 1'($urandom_range(0, 4) != 0));
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule